// File: doc/BRIEF.md
# Triangular Nested Loop Index Generator

This block drives the addressing for a solver that walks the lower triangle of a square matrix row by row, as back substitution does. It keeps a row counter and a column counter. For row r the column index steps through 0, 1, ..., r. When the column reaches r, the row advances and the column returns to zero. On each cycle that the block is running and `enable` is high, it presents one (row, column) pair with a valid flag. It also marks the first and the last element of each row.

A sweep begins with a one-cycle `start`. The sweep ends after the pair (ROWS-1, ROWS-1) has been issued. A one-cycle done pulse follows, and the block then stays idle until the next `start`. Holding `enable` low freezes the sequence, which gives the consuming datapath a simple way to stall it. A `start` issued during a sweep abandons that sweep and begins again from (0, 0).

Top module: `tri_index_gen`

## Requirements
- R1: During and after a synchronous active-low reset, `idx_valid`, `row_first`, `row_last` and `sweep_done` are 0 and both indices are 0.
- R2: The cycle in which `start` is high issues no pair (`idx_valid` = 0). The first pair issued after `start` is (0, 0).
- R3: Within row r the column index issued increases by one per issued pair, from 0 up to and including r. It never exceeds the row index.
- R4: After row r ends (column = r), the next issued pair is (r+1, 0). The row index changes at no other point.
- R5: With ROWS = 16, one sweep issues exactly ROWS*(ROWS+1)/2 = 136 pairs.
- R6: When `enable` is low and `start` is low, `idx_valid` is 0 and both indices hold their values.
- R7: `row_first` is 1 exactly when `idx_valid` is 1 and the column index is 0.
- R8: `row_last` is 1 exactly when `idx_valid` is 1 and the column index equals the row index.
- R9: `sweep_done` is high for exactly one cycle: the cycle after the pair (ROWS-1, ROWS-1) is issued. From then until the next `start`, `idx_valid` stays 0 even with `enable` high.
- R10: A `start` during a sweep restarts the sequence: the following cycle presents (0, 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin (or restart) a sweep |
| enable | input | 1 | Issue one pair this cycle when running |
| row_idx | output | IDX_W | Row (outer) index |
| col_idx | output | IDX_W | Column (inner) index |
| idx_valid | output | 1 | Current pair is issued this cycle |
| row_first | output | 1 | Issued pair is the first of its row |
| row_last | output | 1 | Issued pair is the last of its row |
| sweep_done | output | 1 | One-cycle pulse after the final pair |

## Verification
The pair, the valid flag and both markers follow the counters and `enable` in the same cycle, so the bench drives inputs on the falling edge and samples one time unit later, before the next rising edge. The counters move one rising edge after an issued pair. The next sample therefore expects the advanced pair, and after `start` it expects (0, 0). `sweep_done` comes from a register and is checked in the sample one cycle after the final pair was sampled as issued. A reset applied at a falling edge is checked in the sample after the following rising edge.

// File: rtl/tri_idx_pkg.sv
// Package: shared types for the triangular index generator.
// Assumes nothing beyond IEEE 1800-2017 packed types.
package tri_idx_pkg;

    // Sequencer state: idle between sweeps, running during a sweep.
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // Per-pair position markers derived from the indices.
    typedef struct packed {
        logic first;
        logic last;
        logic row_end;
    } pos_flags_t;

endpackage

// File: rtl/tri_seq_ctrl.sv
// Module: sweep sequencer. Tracks idle/running and produces the done pulse.
// Assumes start has priority over everything else in the same cycle.
module tri_seq_ctrl
    import tri_idx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic enable,
    input  logic sweep_end,
    output logic issue,
    output logic done
);

    seq_state_e state_q;

    // A pair is issued only while running, enabled and not restarting.
    always_comb begin
        issue = (state_q == SEQ_RUN) && enable && !start;
    end

    // State and done pulse update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                state_q <= SEQ_RUN;
            end else if (issue && sweep_end) begin
                state_q <= SEQ_IDLE;
                done    <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/tri_col_counter.sv
// Module: inner (column) counter. It steps once per issued pair and
// returns to zero when the row ends. Assumes wrap is asserted at column == row.
module tri_col_counter #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic             wrap,
    output logic [IDX_W-1:0] col
);

    localparam logic [IDX_W-1:0] ONE = {{(IDX_W-1){1'b0}}, 1'b1};

    // Column register: clear on start, step or wrap on each issue.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            col <= '0;
        end else if (step) begin
            col <= wrap ? '0 : col + ONE;
        end
    end

endmodule

// File: rtl/tri_row_counter.sv
// Module: outer (row) counter. It advances when the current row ends,
// except on the final row. Assumes the sequencer stops issuing after the final row.
module tri_row_counter #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic             row_end,
    input  logic             final_row,
    output logic [IDX_W-1:0] row
);

    localparam logic [IDX_W-1:0] ONE = {{(IDX_W-1){1'b0}}, 1'b1};

    // Row register: clear on start, advance at the end of a non-final row.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            row <= '0;
        end else if (step && row_end && !final_row) begin
            row <= row + ONE;
        end
    end

endmodule

// File: rtl/tri_marker.sv
// Module: position decode. Compares the indices against each other and
// against the last row. Assumes the indices come straight from the counters.
module tri_marker
    import tri_idx_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int ROWS  = 16
) (
    input  logic [IDX_W-1:0] row,
    input  logic [IDX_W-1:0] col,
    input  logic             issue,
    output pos_flags_t       flags,
    output logic             final_row,
    output logic             sweep_end
);

    localparam logic [IDX_W-1:0] LAST_ROW = IDX_W'(ROWS - 1);

    // Row-end and last-row comparisons, gated markers for the outputs.
    always_comb begin
        flags.row_end = (col == row);
        flags.first   = issue && (col == '0);
        flags.last    = issue && flags.row_end;
        final_row     = (row == LAST_ROW);
        sweep_end     = flags.row_end && final_row;
    end

endmodule

// File: rtl/tri_index_gen.sv
// Module: top of the triangular index generator. It issues the pairs
// (row, col) with col = 0..row for row = 0..ROWS-1, one pair per enabled cycle.
// Assumes ROWS <= 2**IDX_W.
module tri_index_gen
    import tri_idx_pkg::*;
#(
    parameter int ROWS  = 16,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             enable,
    output logic [IDX_W-1:0] row_idx,
    output logic [IDX_W-1:0] col_idx,
    output logic             idx_valid,
    output logic             row_first,
    output logic             row_last,
    output logic             sweep_done
);

    logic       issue;
    logic       final_row;
    logic       sweep_end;
    pos_flags_t flags;

    tri_seq_ctrl u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .enable    (enable),
        .sweep_end (sweep_end),
        .issue     (issue),
        .done      (sweep_done)
    );

    tri_row_counter #(.IDX_W(IDX_W)) u_row (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start),
        .step      (issue),
        .row_end   (flags.row_end),
        .final_row (final_row),
        .row       (row_idx)
    );

    tri_col_counter #(.IDX_W(IDX_W)) u_col (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start),
        .step  (issue),
        .wrap  (flags.row_end),
        .col   (col_idx)
    );

    tri_marker #(.IDX_W(IDX_W), .ROWS(ROWS)) u_mark (
        .row       (row_idx),
        .col       (col_idx),
        .issue     (issue),
        .flags     (flags),
        .final_row (final_row),
        .sweep_end (sweep_end)
    );

    // Drive the remaining outputs from the sequencer and the marker decode.
    always_comb begin
        idx_valid = issue;
        row_first = flags.first;
        row_last  = flags.last;
    end

endmodule

// File: rtl/tri_index_gen_chk.sv
// Module: property checker for tri_index_gen, attached with bind.
// Assumes it observes only the top-level ports.
module tri_index_gen_chk #(
    parameter int ROWS  = 16,
    parameter int IDX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             enable,
    input logic [IDX_W-1:0] row_idx,
    input logic [IDX_W-1:0] col_idx,
    input logic             idx_valid,
    input logic             row_first,
    input logic             row_last,
    input logic             sweep_done
);

    localparam logic [IDX_W-1:0] ONE      = {{(IDX_W-1){1'b0}}, 1'b1};
    localparam logic [IDX_W-1:0] LAST_ROW = IDX_W'(ROWS - 1);

    // R3
    col_le_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_valid |-> (col_idx <= row_idx));

    // R3
    col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_valid && (col_idx != row_idx) && !start) |=>
            ((col_idx == $past(col_idx) + ONE) && (row_idx == $past(row_idx))));

    // R4
    row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_valid && (col_idx == row_idx) && (row_idx != LAST_ROW) && !start) |=>
            ((row_idx == $past(row_idx) + ONE) && (col_idx == '0)));

    // R6
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !start) |=> ($stable(row_idx) && $stable(col_idx)));

    // R6
    no_valid_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !idx_valid);

    // R7
    first_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_first |-> (idx_valid && (col_idx == '0)));

    // R8
    last_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_last |-> (idx_valid && (col_idx == row_idx)));

    // R9
    done_after_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_valid && (row_idx == LAST_ROW) && (col_idx == LAST_ROW) && !start) |=> sweep_done);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_done |=> !sweep_done);

    // R9
    done_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_done |-> !idx_valid);

    // R2
    start_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !idx_valid);

    // R10
    restart_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> ((row_idx == '0) && (col_idx == '0)));

endmodule

bind tri_index_gen tri_index_gen_chk #(.ROWS(ROWS), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .enable     (enable),
    .row_idx    (row_idx),
    .col_idx    (col_idx),
    .idx_valid  (idx_valid),
    .row_first  (row_first),
    .row_last   (row_last),
    .sweep_done (sweep_done)
);

// File: tb/tri_index_gen_bench.sv
// Bench: a vector table for the first rows and a restart, then directed
// tests covering a full sweep, enable gaps, restart from idle and reset.
module tri_index_gen_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ROWS       = 16;
    localparam int IDX_W      = 8;
    localparam int NVEC       = 12;

    typedef struct packed {
        logic       st;
        logic       en;
        logic       v;
        logic [7:0] r;
        logic [7:0] c;
        logic       f;
        logic       l;
        logic       d;
    } vec_t;

    // One entry per cycle: inputs driven, then the outputs expected in that cycle.
    localparam vec_t TBL [0:NVEC-1] = '{
        '{1'b1, 1'b0, 1'b0, 8'd0, 8'd0, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b1, 1'b1, 8'd0, 8'd0, 1'b1, 1'b1, 1'b0},
        '{1'b0, 1'b1, 1'b1, 8'd1, 8'd0, 1'b1, 1'b0, 1'b0},
        '{1'b0, 1'b0, 1'b0, 8'd1, 8'd1, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b1, 1'b1, 8'd1, 8'd1, 1'b0, 1'b1, 1'b0},
        '{1'b0, 1'b1, 1'b1, 8'd2, 8'd0, 1'b1, 1'b0, 1'b0},
        '{1'b0, 1'b1, 1'b1, 8'd2, 8'd1, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b1, 1'b1, 8'd2, 8'd2, 1'b0, 1'b1, 1'b0},
        '{1'b0, 1'b0, 1'b0, 8'd3, 8'd0, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b1, 1'b1, 8'd3, 8'd0, 1'b1, 1'b0, 1'b0},
        '{1'b1, 1'b1, 1'b0, 8'd3, 8'd1, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b1, 1'b1, 8'd0, 8'd0, 1'b1, 1'b1, 1'b0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             enable = 1'b0;
    logic [IDX_W-1:0] row_idx;
    logic [IDX_W-1:0] col_idx;
    logic             idx_valid;
    logic             row_first;
    logic             row_last;
    logic             sweep_done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    tri_index_gen #(.ROWS(ROWS), .IDX_W(IDX_W)) u_tri_index_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .enable     (enable),
        .row_idx    (row_idx),
        .col_idx    (col_idx),
        .idx_valid  (idx_valid),
        .row_first  (row_first),
        .row_last   (row_last),
        .sweep_done (sweep_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive inputs at the falling edge and settle just after it.
    task automatic step(input logic s, input logic e);
        @(negedge clk);
        start  = s;
        enable = e;
        #1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int nvalid;
        logic [7:0] er;
        logic [7:0] ec;
        logic [15:0] lfsr;

        // R1: reset state.
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        chk(!idx_valid && !sweep_done && !row_first && !row_last, "R1 flags", idx_valid, 0);
        chk(row_idx == 0 && col_idx == 0, "R1 indices", {row_idx, col_idx}, 0);
        rst_n = 1'b1;

        // Vector table: R2, R3, R4, R6, R7, R8, R10.
        for (int i = 0; i < NVEC; i++) begin
            step(TBL[i].st, TBL[i].en);
            chk(idx_valid == TBL[i].v, "R2/R6 valid", idx_valid, TBL[i].v);
            chk(row_idx == TBL[i].r, "R4 row", row_idx, TBL[i].r);
            chk(col_idx == TBL[i].c, "R3 col", col_idx, TBL[i].c);
            chk(row_first == TBL[i].f, "R7 first", row_first, TBL[i].f);
            chk(row_last == TBL[i].l, "R8 last", row_last, TBL[i].l);
            chk(sweep_done == TBL[i].d, "R10 done", sweep_done, TBL[i].d);
        end

        // Full sweep with enable held high: R3, R4, R5, R9.
        step(1'b1, 1'b1);
        chk(!idx_valid, "R2 start cycle", idx_valid, 0);
        nvalid = 0;
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c <= r; c++) begin
                step(1'b0, 1'b1);
                if (idx_valid) nvalid++;
                chk(idx_valid && row_idx == r[7:0] && col_idx == c[7:0], "R3/R4 pair",
                    {row_idx, col_idx}, {r[7:0], c[7:0]});
                chk(row_first == (c == 0) && row_last == (c == r), "R7/R8 markers",
                    {row_first, row_last}, {(c == 0), (c == r)});
                chk(!sweep_done, "R9 early done", sweep_done, 0);
            end
        end
        chk(nvalid == ROWS * (ROWS + 1) / 2, "R5 count", nvalid, 136);
        step(1'b0, 1'b1);
        chk(sweep_done && !idx_valid, "R9 done pulse", {sweep_done, idx_valid}, 2);
        step(1'b0, 1'b1);
        chk(!sweep_done, "R9 done width", sweep_done, 0);
        chk(!idx_valid, "R9 idle after done", idx_valid, 0);
        step(1'b0, 1'b1);
        chk(!idx_valid, "R9 idle stays", idx_valid, 0);

        // Restart from idle with enable gaps: R6, R10 and ordering.
        step(1'b1, 1'b0);
        er = 8'd0;
        ec = 8'd0;
        lfsr = 16'hACE1;
        nvalid = 0;
        for (int k = 0; k < 400 && nvalid < 136; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(1'b0, lfsr[0] | lfsr[3]);
            if (enable) begin
                chk(idx_valid && row_idx == er && col_idx == ec, "R10 gap pair",
                    {row_idx, col_idx}, {er, ec});
                nvalid++;
                if (ec == er) begin
                    er = er + 8'd1;
                    ec = 8'd0;
                end else begin
                    ec = ec + 8'd1;
                end
            end else begin
                chk(!idx_valid && row_idx == er && col_idx == ec, "R6 hold",
                    {idx_valid, row_idx, col_idx}, {1'b0, er, ec});
            end
        end
        chk(nvalid == 136, "R5 gap count", nvalid, 136);
        step(1'b0, 1'b0);
        chk(sweep_done, "R9 done after gaps", sweep_done, 1);

        // Reset in mid-sweep: R1.
        step(1'b1, 1'b1);
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        step(1'b0, 1'b1);
        chk(!idx_valid && row_idx == 0 && col_idx == 0 && !sweep_done, "R1 mid reset",
            {idx_valid, row_idx, col_idx}, 0);
        rst_n = 1'b1;
        step(1'b0, 1'b1);
        chk(!idx_valid, "R1 idle after reset", idx_valid, 0);

        finish_run();
    end

endmodule